// File: doc/BRIEF.md
# Selectable Master-Clock Frame Timer

The block produces the 8 kHz frame timing of a voice-band converter from one master clock. That clock may run at one of three rates: 1.536 MHz, 1.544 MHz or 2.048 MHz. A single counter serves all three. Its terminal count is chosen from the state of a shared select pin. The pin may carry a clock, sit low, or sit high. A clock on the pin also means that the receive direction has a bit clock of its own. A static level means one bit clock is shared by both directions.

In the 1.544 MHz case every frame holds 193 master-clock pulses. The block absorbs the extra pulse: on the 193rd count the sample phase does not advance, and a hold flag marks that cycle. Every transmit frame-sync pulse forces the counter back to zero, so a stray count cannot build up. The frame-sync and select inputs are assumed synchronous to the master clock. The select pin is still passed through a short synchronizer before edges are detected on it.

Top module: `frame_timer`

## Requirements
- R1: While reset is held, frame_o = 1, phase_o = 0, hold_o = 0, rate_o = 0 and shared_bclk_o = 1.
- R2: When sel_i stays low for a full detection window, rate_o settles to 0 (192 counts per frame, 1.536 MHz) and shared_bclk_o to 1.
- R3: When sel_i stays high for a full detection window, rate_o settles to 1 (193 counts per frame, 1.544 MHz) and shared_bclk_o to 1.
- R4: When sel_i shows at least one transition in every detection window, rate_o settles to 2 (256 counts per frame, 2.048 MHz) and shared_bclk_o to 0.
- R5: With no frame sync, the internal count runs 0 to N-1 and wraps to 0, with N = 192, 193 or 256 for rate codes 0, 1 or 2. frame_o is 1 exactly when the count is 0.
- R6: phase_o equals the count. The one exception is the swallowed count 192 at rate 1: there phase_o stays at 191 and hold_o = 1. In every other cycle hold_o = 0.
- R7: A high fs_i at a clock edge makes the count 0 after that edge: frame_o = 1 and phase_o = 0 in the next cycle.
- R8: When the rate code drops to one with a shorter frame and the count is already past the new end, the count wraps to 0 on the next edge. phase_o never reaches N in a cycle whose rate code matches that of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Combined clock-select / receive bit clock pin |
| fs_i | input | 1 | Transmit frame-sync pulse, realigns the count |
| frame_o | output | 1 | High in the cycle the count is 0 |
| phase_o | output | 8 | Sample phase, held during the swallowed pulse |
| hold_o | output | 1 | High on the swallowed 193rd pulse |
| rate_o | output | 2 | Detected rate: 0 = 192, 1 = 193, 2 = 256 counts |
| shared_bclk_o | output | 1 | High when the select pin is a static level |

## Verification
The count registers fs_i at the edge where it is sampled, so frame_o and phase_o show the realignment one cycle later. The bench's reference counter steps at the same edge, and the outputs are compared at the following falling edge. A select change passes through two synchronizer stages and at most two detection windows before rate_o moves. For that reason the bench waits three full windows before it checks the rate code. It then issues a frame sync so that its model and the design start from the same count. The rate-drop wrap is watched on every cycle with a one-cycle history of rate_o.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  localparam int CNT_W   = 9;
  localparam int PHASE_W = 8;

  typedef enum logic [1:0] {
    RATE_1536 = 2'd0,
    RATE_1544 = 2'd1,
    RATE_2048 = 2'd2
  } rate_e;

  function automatic logic [CNT_W-1:0] frame_len(rate_e r);
    case (r)
      RATE_1544: frame_len = CNT_W'(193);
      RATE_2048: frame_len = CNT_W'(256);
      default:   frame_len = CNT_W'(192);
    endcase
  endfunction
endpackage

// File: rtl/sel_detect.sv
module sel_detect
  import frame_timer_pkg::*;
#(
  parameter int WIN_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_i,
  output rate_e rate_o,
  output logic  shared_o
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [SYNC_STAGES:0] sync_q;
  logic [WIN_W-1:0]     win_q;
  logic                 seen_q;
  logic                 edge_now;
  logic                 win_end;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= sel_i;
        else sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign edge_now = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign win_end  = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      seen_q   <= 1'b0;
      rate_o   <= RATE_1536;
      shared_o <= 1'b1;
    end else begin
      win_q <= win_end ? '0 : win_q + 1'b1;
      if (win_end) begin
        seen_q <= 1'b0;
        if (seen_q || edge_now) begin
          rate_o   <= RATE_2048;
          shared_o <= 1'b0;
        end else begin
          rate_o   <= sync_q[SYNC_STAGES-1] ? RATE_1544 : RATE_1536;
          shared_o <= 1'b1;
        end
      end else if (edge_now) begin
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_ctr.sv
module frame_ctr
  import frame_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rate_e              rate_i,
  input  logic               fs_i,
  output logic               frame_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               hold_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = frame_len(rate_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fs_i)          cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;  // also catches a rate drop
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // 193rd pulse: phase stands still
  assign hold_o  = (rate_i == RATE_1544) && (cnt_q == CNT_W'(192));
  assign frame_o = (cnt_q == '0);
  assign phase_o = hold_o ? PHASE_W'(191) : cnt_q[PHASE_W-1:0];
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import frame_timer_pkg::*;
#(
  parameter int WIN_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         fs_i,
  output logic         frame_o,
  output logic [7:0]   phase_o,
  output logic         hold_o,
  output logic [1:0]   rate_o,
  output logic         shared_bclk_o
);
  rate_e rate;

  sel_detect #(.WIN_LEN(WIN_LEN), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .rate_o   (rate),
    .shared_o (shared_bclk_o)
  );

  frame_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate),
    .fs_i    (fs_i),
    .frame_o (frame_o),
    .phase_o (phase_o),
    .hold_o  (hold_o)
  );

  assign rate_o = rate;
endmodule

// File: rtl/frame_timer_chk.sv
module frame_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fs_i,
  input logic       frame_o,
  input logic [7:0] phase_o,
  input logic       hold_o,
  input logic [1:0] rate_o
);
  AST_FRAME_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> phase_o == 8'd0); // R5
  AST_SYNC_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |=> frame_o && phase_o == 8'd0); // R7
  AST_HOLD_ONLY_1544: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> rate_o == 2'd1 && phase_o == 8'd191); // R6
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_i && phase_o < 8'd190) |=> (phase_o == $past(phase_o) + 8'd1) || $changed(rate_o)); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_o == 2'd0 && $stable(rate_o)) |-> phase_o < 8'd192); // R8
endmodule

bind frame_timer frame_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fs_i    (fs_i),
  .frame_o (frame_o),
  .phase_o (phase_o),
  .hold_o  (hold_o),
  .rate_o  (rate_o)
);

// File: tb/sim_frame_timer.sv
`timescale 1ns/1ps
module sim_frame_timer;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       fs = 1'b0;
  logic       frame;
  logic [7:0] phase;
  logic       hold;
  logic [1:0] rate;
  logic       shared;

  int  checks = 0;
  int  fails = 0;
  int  len_n = 192;
  int  m_cnt = 0;
  bit  cmp_en = 1'b0;
  bit  sel_clk = 1'b0;
  bit  sel_lvl = 1'b0;
  int  overrun = 0;
  logic [1:0] rate_prev = 2'd0;

  always #2.5 clk = ~clk;

  frame_timer #(.WIN_LEN(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .fs_i(fs),
    .frame_o(frame), .phase_o(phase), .hold_o(hold),
    .rate_o(rate), .shared_bclk_o(shared)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) sel <= sel_clk ? ~sel : sel_lvl;

  // reference count
  always @(posedge clk) begin
    if (fs || m_cnt >= len_n - 1) m_cnt <= 0;
    else m_cnt <= m_cnt + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rate == 2'd0 && rate_prev == 2'd0 && phase >= 8'd192) overrun++;
      rate_prev <= rate;
    end
    if (cmp_en) begin
      automatic bit sw = (len_n == 193) && (m_cnt == 192);
      chk("R5 frame", int'(frame), int'(m_cnt == 0));
      chk("R6 phase", int'(phase), sw ? 191 : m_cnt);
      chk("R6 hold", int'(hold), int'(sw));
    end
  end

  task automatic settle();
    repeat (3 * WIN + 6) @(negedge clk);
  endtask

  task automatic sync_pulse();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic run_mode(input int n, input int cyc, input int mid_sync);
    cmp_en = 1'b0;
    len_n = n;
    sync_pulse();
    cmp_en = 1'b1;
    chk("R7 frame after sync", int'(frame), 1);
    chk("R7 phase after sync", int'(phase), 0);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (i == mid_sync) fs = 1'b1;
      else fs = 1'b0;
    end
    fs = 1'b0;
    @(negedge clk);
    cmp_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 frame", int'(frame), 1);
    chk("R1 phase", int'(phase), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 rate", int'(rate), 0);
    chk("R1 shared", int'(shared), 1);
    rst_n = 1'b1;

    sel_lvl = 1'b0; settle();
    chk("R2 rate", int'(rate), 0);
    chk("R2 shared", int'(shared), 1);
    run_mode(192, 450, 100);

    sel_clk = 1'b1; settle();
    chk("R4 rate", int'(rate), 2);
    chk("R4 shared", int'(shared), 0);
    run_mode(256, 600, 333);

    sel_clk = 1'b0; sel_lvl = 1'b1; settle();
    chk("R3 rate", int'(rate), 1);
    chk("R3 shared", int'(shared), 1);
    run_mode(193, 500, 450);

    // R8: drop from 256 to 192 counts with the count past 191
    sel_clk = 1'b1; settle();
    sync_pulse();
    repeat (220) @(negedge clk);
    sel_clk = 1'b0; sel_lvl = 1'b0;
    settle(); settle();
    chk("R8 rate after drop", int'(rate), 0);
    chk("R8 overrun cycles", overrun, 0);
    len_n = 192;
    run_mode(192, 400, 1000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule